// File: doc/BRIEF.md
# Multi-lane word alignment controller

This block brings several parallel 1:16 deserializer lanes into word alignment, so that bits launched in the same time period show up at the same bit position on every lane. During training the far end repeatedly sends a 16-bit word that holds a single one followed by fifteen zeros. Each lane's parallel output is compared against that word. A misaligned lane gets its slip line raised for a fixed number of clocks. The deserializer then drops one bit, which moves its word boundary by one position. The controller waits for fresh words to arrive and checks again.

All lanes share one clock domain, taken from a common reference. Every lane runs its own state machine with these states:

- **SEARCH**: examines incoming words.
- **PULSE**: drives the slip line.
- **SETTLE**: waits for the deserializer to deliver words at the new boundary.
- **LOCKED**: the lane is aligned.
- **ERROR**: too many slips without success.

The transitions are:

- **match-run**: SEARCH to LOCKED after three matches in a row.
- **miss**: SEARCH to PULSE on a mismatch.
- **hold-done**: PULSE to SETTLE after the slip line has been high for four clocks.
- **settle-done**: SETTLE to SEARCH after 16 clocks.
- **loss**: LOCKED to SEARCH after four misses in a row while training is on.
- **give-up**: SEARCH to ERROR on a mismatch once 16 slips are used up.
- **clear**: ERROR to SEARCH when training is switched off.

An overall flag reports when every lane is locked at once.

Top module: `lane_align_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after reset, all slip, lock and error outputs are low.
- R2: A lane's slip output, when raised, stays high for exactly 4 consecutive clocks. Each such pulse makes the deserializer drop exactly one bit.
- R3: After each slip pulse the lane waits 16 clocks before it judges words again. A lane starting at bit offset k reaches alignment after exactly (16-k) mod 16 slips.
- R4: A lane in SEARCH with training on becomes locked after three consecutive clocks whose word equals the training word. The lock output is high in the clock after the third match.
- R5: A locked lane with training on leaves lock, returning to SEARCH, after four consecutive mismatching words. Three mismatches followed by a match leave it locked.
- R6: With training off, word contents are ignored: a locked lane stays locked, and a lane in SEARCH issues no slip.
- R7: A lane that mismatches in SEARCH after 16 slips without locking raises its error output and stops slipping. The error stays up while training is on and clears when training is turned off.
- R8: The all-locked output is high exactly when every lane is locked in the same cycle.
- R9: The training word is 16'h8000: bit 15 carries the first received bit and is the single one.
- R10: Once all lanes are locked, every lane presents the training word in the same cycle, so the lanes are aligned to each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common word clock shared by all lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_en | input | 1 | High while the training word is being sent |
| lane_word | input | 64 | Parallel words, lane l at bits [16l+15:16l] |
| slip_req | output | 4 | Per-lane slip line to the deserializer |
| lane_locked | output | 4 | Per-lane lock indication |
| align_err | output | 4 | Per-lane alignment failure flag |
| all_locked | output | 1 | All lanes locked together |

## Verification
The hardest state to reach from the ports is the give-up path. A deserializer model that is merely offset always converges within 15 slips, so a lane never exhausts its slip budget. The bench therefore forces one lane's word to all zeros, so that no slip can ever produce a match. It then checks that exactly 16 slips occur before the error flag rises, and that the flag clears only when training stops. The loss-of-lock boundary is reached by corrupting a locked lane for exactly three words and then for exactly four. A behavioural reference model is compared against every output on every clock.

// File: rtl/align_pkg.sv
package align_pkg;
    typedef enum logic [2:0] {
        ST_SEARCH,
        ST_PULSE,
        ST_SETTLE,
        ST_LOCKED,
        ST_ERROR
    } lane_state_t;
endpackage

// File: rtl/align_word_match.sv
module align_word_match #(
    parameter int                 WORD_W  = 16,
    parameter logic [WORD_W-1:0]  PATTERN = {1'b1, {(WORD_W-1){1'b0}}}
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = (word_i == PATTERN);
    end
endmodule

// File: rtl/align_lane.sv
module align_lane
    import align_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int SLIP_HOLD    = 4,
    parameter int SETTLE_CYC   = 16,
    parameter int LOCK_MATCHES = 3,
    parameter int LOSS_MISSES  = 4,
    parameter int MAX_SLIPS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_en_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              slip_o,
    output logic              locked_o,
    output logic              err_o
);
    localparam logic [WORD_W-1:0] TRAIN_WORD = {1'b1, {(WORD_W-1){1'b0}}};
    localparam int CNT_W = $clog2(SLIP_HOLD + SETTLE_CYC + LOCK_MATCHES + LOSS_MISSES + 1);
    localparam int SLP_W = $clog2(MAX_SLIPS + 1);

    lane_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SLP_W-1:0] slips_q, slips_d;
    logic             hit;

    align_word_match #(.WORD_W(WORD_W), .PATTERN(TRAIN_WORD)) u_match (
        .word_i(word_i),
        .hit_o (hit)
    );

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        slips_d = slips_q;
        unique case (state_q)
            ST_SEARCH: begin
                if (!train_en_i) begin
                    cnt_d = '0;
                end else if (hit) begin
                    if (cnt_q == CNT_W'(LOCK_MATCHES - 1)) begin
                        state_d = ST_LOCKED;   // match-run
                        cnt_d   = '0;
                        slips_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else if (slips_q == SLP_W'(MAX_SLIPS)) begin
                    state_d = ST_ERROR;        // give-up
                    cnt_d   = '0;
                end else begin
                    state_d = ST_PULSE;        // miss
                    cnt_d   = '0;
                    slips_d = slips_q + 1'b1;
                end
            end
            ST_PULSE: begin
                if (cnt_q == CNT_W'(SLIP_HOLD - 1)) begin
                    state_d = ST_SETTLE;       // hold-done
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
                    state_d = ST_SEARCH;       // settle-done
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LOCKED: begin
                if (train_en_i && !hit) begin
                    if (cnt_q == CNT_W'(LOSS_MISSES - 1)) begin
                        state_d = ST_SEARCH;   // loss
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else begin
                    cnt_d = '0;
                end
            end
            ST_ERROR: begin
                if (!train_en_i) begin
                    state_d = ST_SEARCH;       // clear
                    cnt_d   = '0;
                    slips_d = '0;
                end
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            cnt_q   <= '0;
            slips_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            slips_q <= slips_d;
        end
    end

    // outputs
    always_comb begin
        slip_o   = (state_q == ST_PULSE);
        locked_o = (state_q == ST_LOCKED);
        err_o    = (state_q == ST_ERROR);
    end

    // length of the current slip run, kept for the pulse-width check
    logic [CNT_W-1:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_run <= '0;
        else if (slip_o) hi_run <= hi_run + 1'b1;
        else             hi_run <= '0;
    end

    AST_SLIP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slip_o) |-> hi_run == CNT_W'(SLIP_HOLD)); // R2
    AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(word_i == TRAIN_WORD && train_en_i)); // R4
    AST_LOCK_KEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!train_en_i && locked_o) |-> locked_o); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_o && train_en_i) |-> err_o); // R7
    AST_SLIP_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        slips_q <= SLP_W'(MAX_SLIPS)); // R7
endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl #(
    parameter int LANES        = 4,
    parameter int WORD_W       = 16,
    parameter int SLIP_HOLD    = 4,
    parameter int SETTLE_CYC   = 16,
    parameter int LOCK_MATCHES = 3,
    parameter int LOSS_MISSES  = 4,
    parameter int MAX_SLIPS    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    train_en,
    input  logic [LANES*WORD_W-1:0] lane_word,
    output logic [LANES-1:0]        slip_req,
    output logic [LANES-1:0]        lane_locked,
    output logic [LANES-1:0]        align_err,
    output logic                    all_locked
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        align_lane #(
            .WORD_W      (WORD_W),
            .SLIP_HOLD   (SLIP_HOLD),
            .SETTLE_CYC  (SETTLE_CYC),
            .LOCK_MATCHES(LOCK_MATCHES),
            .LOSS_MISSES (LOSS_MISSES),
            .MAX_SLIPS   (MAX_SLIPS)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .train_en_i(train_en),
            .word_i    (lane_word[g*WORD_W +: WORD_W]),
            .slip_o    (slip_req[g]),
            .locked_o  (lane_locked[g]),
            .err_o     (align_err[g])
        );
    end

    always_comb begin
        all_locked = &lane_locked;
    end

    AST_ALL_NEEDS_EACH: assert property (@(posedge clk) disable iff (!rst_n)
        all_locked |-> align_err == '0 && slip_req == '0); // R8
endmodule

// File: tb/lane_align_ctrl_tb.sv
`timescale 1ns/1ps
module lane_align_ctrl_tb;
    localparam int NL = 4;
    localparam int WW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_en = 1'b0;
    logic [NL*WW-1:0] lane_word;
    logic [NL-1:0] slip_req, lane_locked, align_err;
    logic all_locked;

    always #4 clk = ~clk;

    lane_align_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .train_en(train_en), .lane_word(lane_word),
        .slip_req(slip_req), .lane_locked(lane_locked), .align_err(align_err),
        .all_locked(all_locked)
    );

    int errors = 0;
    int checks = 0;
    int offs[NL];
    int hold[NL];
    int slip_total[NL];
    bit stuck[NL];
    bit corrupt[NL];
    int m_st[NL];
    int m_cnt[NL];
    int m_slips[NL];
    bit train_next = 1'b0;
    bit rst_q = 1'b0;
    bit done = 1'b0;
    int cyc = 0;

    always @(posedge clk) rst_q <= rst_n;

    function automatic logic [WW-1:0] word_of(int l);
        logic [WW-1:0] w;
        if (stuck[l]) return '0;
        w = 16'h8000 >> ((16 - offs[l]) % 16);
        if (corrupt[l]) w = w ^ 16'h0001;
        return w;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // reference model (state codes: 0 search, 1 pulse, 2 settle, 3 locked, 4 error),
    // deserializer model and stimulus application, all on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            int nlock;
            cyc++;
            for (int l = 0; l < NL; l++) begin
                bit m;
                m = (lane_word[l*WW +: WW] == 16'h8000);
                if (!rst_q) begin
                    m_st[l] = 0; m_cnt[l] = 0; m_slips[l] = 0;
                end else begin
                    case (m_st[l])
                        0: if (!train_en) m_cnt[l] = 0;
                           else if (m) begin
                               if (m_cnt[l] == 2) begin m_st[l] = 3; m_cnt[l] = 0; m_slips[l] = 0; end
                               else m_cnt[l]++;
                           end else if (m_slips[l] == 16) begin m_st[l] = 4; m_cnt[l] = 0; end
                           else begin m_st[l] = 1; m_cnt[l] = 0; m_slips[l]++; end
                        1: if (m_cnt[l] == 3) begin m_st[l] = 2; m_cnt[l] = 0; end else m_cnt[l]++;
                        2: if (m_cnt[l] == 15) begin m_st[l] = 0; m_cnt[l] = 0; end else m_cnt[l]++;
                        3: if (train_en && !m) begin
                               if (m_cnt[l] == 3) begin m_st[l] = 0; m_cnt[l] = 0; end
                               else m_cnt[l]++;
                           end else m_cnt[l] = 0;
                        default: if (!train_en) begin m_st[l] = 0; m_cnt[l] = 0; m_slips[l] = 0; end
                    endcase
                end
            end
            nlock = 0;
            for (int l = 0; l < NL; l++) begin
                chk(slip_req[l] == (m_st[l] == 1), "R2", "slip_req", slip_req[l], m_st[l] == 1);
                chk(lane_locked[l] == (m_st[l] == 3), "R4", "lane_locked", lane_locked[l], m_st[l] == 3);
                chk(align_err[l] == (m_st[l] == 4), "R7", "align_err", align_err[l], m_st[l] == 4);
                if (m_st[l] == 3) nlock++;
            end
            chk(all_locked == (nlock == NL), "R8", "all_locked", all_locked, nlock == NL);
            for (int l = 0; l < NL; l++) begin
                if (slip_req[l]) hold[l]++;
                else begin
                    if (hold[l] >= 4) begin
                        offs[l] = (offs[l] + 1) % 16;
                        slip_total[l]++;
                    end
                    hold[l] = 0;
                end
            end
            train_en = train_next;
            for (int l = 0; l < NL; l++) lane_word[l*WW +: WW] = word_of(l);
            if (cyc > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: got %0d cycles expected completion", cyc);
                finish_run();
            end
        end
    end

    initial begin
        offs = '{5, 0, 11, 15};
        for (int l = 0; l < NL; l++) begin
            hold[l] = 0; slip_total[l] = 0; stuck[l] = 0; corrupt[l] = 0;
            m_st[l] = 0; m_cnt[l] = 0; m_slips[l] = 0;
            lane_word[l*WW +: WW] = word_of(l);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slip_req == '0 && lane_locked == '0 && align_err == '0 && !all_locked,
            "R1", "outputs after reset", {slip_req, lane_locked, align_err}, 0);

        // R3 R9 R10: train from offsets 5, 0, 11, 15
        @(posedge clk); train_next = 1'b1;
        for (int i = 0; i < 3000 && !all_locked; i++) @(negedge clk);
        chk(all_locked == 1'b1, "R8", "all lanes locked", all_locked, 1);
        for (int l = 0; l < NL; l++) begin
            chk(lane_word[l*WW +: WW] == 16'h8000, "R10", "aligned word", lane_word[l*WW +: WW], 16'h8000);
            chk(slip_total[l] == (16 - (l == 0 ? 5 : l == 1 ? 0 : l == 2 ? 11 : 15)) % 16,
                "R3", "slips to lock", slip_total[l], (16 - (l == 0 ? 5 : l == 1 ? 0 : l == 2 ? 11 : 15)) % 16);
        end
        chk(lane_word[15] == 1'b1, "R9", "first bit in bit 15", lane_word[15], 1);

        // R6: training off, bad words ignored
        @(posedge clk); train_next = 1'b0;
        repeat (2) @(posedge clk);
        corrupt[1] = 1'b1;
        repeat (10) @(posedge clk);
        corrupt[1] = 1'b0;
        @(negedge clk);
        chk(lane_locked[1] == 1'b1, "R6", "lock kept with training off", lane_locked[1], 1);
        chk(slip_req == '0, "R6", "no slip with training off", slip_req, 0);

        // R5: three misses keep lock, four lose it
        @(posedge clk); train_next = 1'b1;
        repeat (3) @(posedge clk);
        corrupt[2] = 1'b1;
        repeat (3) @(posedge clk);
        corrupt[2] = 1'b0;
        repeat (3) @(negedge clk);
        chk(lane_locked[2] == 1'b1, "R5", "lock kept after 3 misses", lane_locked[2], 1);
        @(posedge clk);
        corrupt[2] = 1'b1;
        repeat (4) @(posedge clk);
        corrupt[2] = 1'b0;
        @(negedge clk);
        chk(lane_locked[2] == 1'b0, "R5", "lock lost after 4 misses", lane_locked[2], 0);
        chk(all_locked == 1'b0, "R8", "all_locked drops", all_locked, 0);
        for (int i = 0; i < 500 && !lane_locked[2]; i++) @(negedge clk);
        chk(lane_locked[2] == 1'b1, "R4", "relock on good words", lane_locked[2], 1);
        chk(slip_total[2] == 5, "R4", "relock without slip", slip_total[2], 5);

        // R7: a lane that can never match gives up after 16 slips
        @(posedge clk);
        stuck[3] = 1'b1;
        slip_total[3] = 0;
        for (int i = 0; i < 3000 && !align_err[3]; i++) @(negedge clk);
        chk(align_err[3] == 1'b1, "R7", "error raised", align_err[3], 1);
        chk(slip_total[3] == 16, "R7", "slips before error", slip_total[3], 16);
        repeat (20) @(negedge clk);
        chk(align_err[3] == 1'b1 && slip_req[3] == 1'b0, "R7", "error sticky, no slip", align_err[3], 1);
        chk(lane_locked[2:0] == 3'b111, "R8", "other lanes locked", lane_locked[2:0], 7);
        @(posedge clk); train_next = 1'b0;
        repeat (3) @(negedge clk);
        chk(align_err[3] == 1'b0, "R7", "error cleared", align_err[3], 0);
        chk(lane_locked[2:0] == 3'b111, "R6", "locks kept idle", lane_locked[2:0], 7);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule